// File: doc/BRIEF.md
# Battery Charge Cycle Sequencer

This block is a synchronous state machine that runs a battery charge cycle from start to finish with no host involvement. Its inputs are status flags that other logic has already digitized: converter ready, an enable register bit, an active-low enable pin, thermistor and safety-timer faults, and comparator results for the battery voltage against the short, low-voltage and recharge thresholds. Three further flags report that the charge current is below the termination level, that an input or thermal regulation loop is active, and that the battery has reached its regulation voltage.

From these flags the sequencer selects the charge phase and reports it as a 3-bit code. It ends the cycle when the termination conditions are met. The cycle may pass through an optional top-off interval on the way. After termination the sequencer starts a new cycle when the battery sags or when the enable is toggled. Each change of the phase code sends a one-clock interrupt pulse to the host. The top-off length is a cycle count set by a parameter.

Top module: `chg_seq`

## Requirements
- R1: While reset is asserted and after it is released, `phase_o` is 000 (idle) and `irq_o` is low.
- R2: The machine leaves idle only when all five start conditions hold together: converter ready is 1, the enable bit is 1, the enable pin is low, and both the thermistor fault and the timer fault are 0. Otherwise it stays at 000.
- R3: On a start, the first phase is chosen from the battery voltage. Below the short threshold it is 001 (trickle). Between the short and low-voltage thresholds it is 010 (pre-charge). At or above the low-voltage threshold it is 011 (constant-current fast charge).
- R4: Trickle moves to 010 when the voltage exceeds the short threshold. Pre-charge moves to 011 when the voltage exceeds the low-voltage threshold. Fast charge moves to 100 (constant-voltage taper) when the at-regulation flag is set.
- R5: Taper terminates only when three conditions hold in the same cycle: current is below termination, voltage is above the recharge threshold, and no regulation loop is active. With top-off disabled, the next phase is 111 (done).
- R6: With top-off enabled, termination enters 110. The code stays at 110 for exactly TOPOFF_CYCLES clocks and then becomes 111.
- R7: In 111, if the battery falls below the recharge threshold while all start conditions hold, a new cycle starts with the entry phase given by R3.
- R8: In 111, clearing the enable bit or raising the enable pin keeps the code at 111. Restoring the enable afterwards starts a new cycle with the entry phase given by R3.
- R9: During charging (codes 001 to 110), the loss of any start condition returns the code to 000 on the next clock. In 111, a converter, thermistor or timer fault returns the code to 000 on the next clock.
- R10: `irq_o` is high in exactly those cycles in which `phase_o` differs from its value in the previous cycle. The reserved code 101 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_rdy_i | input | 1 | Converter is up |
| chg_en_i | input | 1 | Charge enable register bit |
| ce_ni | input | 1 | Charge enable pin, active low |
| ts_fault_i | input | 1 | Thermistor fault |
| tmr_fault_i | input | 1 | Safety timer fault |
| vbat_gt_short_i | input | 1 | Battery above short threshold |
| vbat_gt_lowv_i | input | 1 | Battery above low-voltage threshold |
| vbat_gt_rechg_i | input | 1 | Battery above recharge threshold |
| ibat_lt_term_i | input | 1 | Charge current below termination |
| reg_loop_i | input | 1 | Input or thermal regulation loop active |
| vbat_at_reg_i | input | 1 | Battery at regulation voltage |
| topoff_en_i | input | 1 | Top-off interval enabled |
| phase_o | output | 3 | Charge phase code |
| irq_o | output | 1 | One-clock interrupt on a phase change |

## Verification
The phase code is a register, so a change in the input flags shows on `phase_o` at the first rising edge after the flags are applied. `irq_o` is registered from the same next-state value, so it rises at that same edge and falls at the following one. After termination with top-off enabled, 111 appears TOPOFF_CYCLES edges after 110 is entered. The bench drives each set of inputs on a falling edge and samples shortly after the next rising edge. Both the phase and the interrupt are therefore compared for the cycle the inputs belong to, and the top-off rows are counted edge by edge.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'b000,
    PH_TRICKLE = 3'b001,
    PH_PRE     = 3'b010,
    PH_FAST    = 3'b011,
    PH_TAPER   = 3'b100,
    PH_TOPOFF  = 3'b110,
    PH_DONE    = 3'b111
  } phase_e;
endpackage

// File: rtl/chg_topoff_tmr.sv
module chg_topoff_tmr #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(CYCLES > 1 ? CYCLES : 2);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!run_i || expire_o)    cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/chg_restart_arm.sv
module chg_restart_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_done_i,
  input  logic en_pair_i,
  output logic restart_o
);
  logic armed_q;

  // arm on a disable seen in done; clear on leaving done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= in_done_i && (armed_q || !en_pair_i);
  end

  assign restart_o = armed_q && en_pair_i;
endmodule

// File: rtl/chg_irq_gen.sv
module chg_irq_gen #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] nxt_i,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= (nxt_i != cur_i);
  end
endmodule

// File: rtl/chg_seq.sv
module chg_seq
  import chg_seq_pkg::*;
#(
  parameter int unsigned TOPOFF_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       conv_rdy_i,
  input  logic       chg_en_i,
  input  logic       ce_ni,
  input  logic       ts_fault_i,
  input  logic       tmr_fault_i,
  input  logic       vbat_gt_short_i,
  input  logic       vbat_gt_lowv_i,
  input  logic       vbat_gt_rechg_i,
  input  logic       ibat_lt_term_i,
  input  logic       reg_loop_i,
  input  logic       vbat_at_reg_i,
  input  logic       topoff_en_i,
  output logic [2:0] phase_o,
  output logic       irq_o
);
  localparam int unsigned PW = $bits(phase_e);

  phase_e ph_q, ph_d, entry_ph;
  logic   hw_fault, en_pair, start_ok, term_ok, topoff_done, tgl_restart;

  assign hw_fault = !conv_rdy_i || ts_fault_i || tmr_fault_i;
  assign en_pair  = chg_en_i && !ce_ni;
  assign start_ok = en_pair && !hw_fault;
  assign term_ok  = ibat_lt_term_i && vbat_gt_rechg_i && !reg_loop_i;

  always_comb begin
    if (!vbat_gt_short_i)     entry_ph = PH_TRICKLE;
    else if (!vbat_gt_lowv_i) entry_ph = PH_PRE;
    else                      entry_ph = PH_FAST;
  end

  chg_topoff_tmr #(.CYCLES(TOPOFF_CYCLES)) u_topoff (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ph_q == PH_TOPOFF),
    .expire_o (topoff_done)
  );

  chg_restart_arm u_arm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_done_i (ph_q == PH_DONE),
    .en_pair_i (en_pair),
    .restart_o (tgl_restart)
  );

  always_comb begin
    ph_d = ph_q;
    if (ph_q != PH_DONE && ph_q != PH_IDLE && !start_ok) begin
      ph_d = PH_IDLE;
    end else begin
      unique case (ph_q)
        PH_IDLE:    if (start_ok) ph_d = entry_ph;
        PH_TRICKLE: if (vbat_gt_short_i) ph_d = PH_PRE;
        PH_PRE:     if (vbat_gt_lowv_i) ph_d = PH_FAST;
        PH_FAST:    if (vbat_at_reg_i) ph_d = PH_TAPER;
        PH_TAPER:   if (term_ok) ph_d = topoff_en_i ? PH_TOPOFF : PH_DONE;
        PH_TOPOFF:  if (topoff_done) ph_d = PH_DONE;
        PH_DONE: begin
          if (hw_fault)                                   ph_d = PH_IDLE;
          else if (en_pair && (tgl_restart || !vbat_gt_rechg_i)) ph_d = entry_ph;
        end
        default:    ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_IDLE;
    else         ph_q <= ph_d;
  end

  chg_irq_gen #(.W(PW)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cur_i  (ph_q),
    .nxt_i  (ph_d),
    .irq_o  (irq_o)
  );

  assign phase_o = ph_q;
endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       conv_rdy_i,
  input logic       chg_en_i,
  input logic       ce_ni,
  input logic       ts_fault_i,
  input logic       tmr_fault_i,
  input logic       ibat_lt_term_i,
  input logic       vbat_gt_rechg_i,
  input logic       reg_loop_i,
  input logic       topoff_en_i,
  input logic [2:0] phase_o,
  input logic       irq_o
);
  logic ok_start, hw_bad, en_off;
  assign hw_bad   = !conv_rdy_i || ts_fault_i || tmr_fault_i;
  assign en_off   = !chg_en_i || ce_ni;
  assign ok_start = !hw_bad && !en_off;

  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |=> (phase_o == 3'b000 && !irq_o));

  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'b000 && !ok_start) |=> phase_o == 3'b000);

  a_r5_no_early_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'b100 && ok_start && !(ibat_lt_term_i && vbat_gt_rechg_i && !reg_loop_i))
    |=> phase_o == 3'b100);

  a_r6_topoff_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'b100 && ok_start && topoff_en_i && ibat_lt_term_i && vbat_gt_rechg_i && !reg_loop_i)
    |=> phase_o == 3'b110);

  a_r9_fault_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_bad |=> phase_o == 3'b000);

  a_r9_disable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_off && phase_o != 3'b111) |=> phase_o == 3'b000);

  a_r8_hold_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'b111 && en_off && !hw_bad) |=> phase_o == 3'b111);

  a_r10_irq_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (phase_o != $past(phase_o)));

  a_r10_no_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != 3'b101);
endmodule

bind chg_seq chg_seq_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .conv_rdy_i      (conv_rdy_i),
  .chg_en_i        (chg_en_i),
  .ce_ni           (ce_ni),
  .ts_fault_i      (ts_fault_i),
  .tmr_fault_i     (tmr_fault_i),
  .ibat_lt_term_i  (ibat_lt_term_i),
  .vbat_gt_rechg_i (vbat_gt_rechg_i),
  .reg_loop_i      (reg_loop_i),
  .topoff_en_i     (topoff_en_i),
  .phase_o         (phase_o),
  .irq_o           (irq_o)
);

// File: tb/sim_chg_seq.sv
`timescale 1ns/1ps
module sim_chg_seq;
  localparam int unsigned TOPOFF_N = 4;
  localparam int unsigned NV = 27;

  // row: {conv,en,ce_n,ts,tmr,gshort,glowv,grechg,iterm,loop,atreg,topen, phase[3], irq}
  localparam logic [15:0] VEC [NV] = '{
    {12'b100000000000, 3'd0, 1'b0},  // R2 enable bit low
    {12'b110000000000, 3'd1, 1'b1},  // R3 trickle entry
    {12'b110000000000, 3'd1, 1'b0},
    {12'b110001000000, 3'd2, 1'b1},  // R4 trickle->pre
    {12'b110001100000, 3'd3, 1'b1},  // R4 pre->fast
    {12'b110001110000, 3'd3, 1'b0},
    {12'b110001110010, 3'd4, 1'b1},  // R4 fast->taper
    {12'b110001111110, 3'd4, 1'b0},  // R5 loop blocks term
    {12'b110001111010, 3'd7, 1'b1},  // R5 term, no top-off
    {12'b110001111010, 3'd7, 1'b0},
    {12'b110001101010, 3'd3, 1'b1},  // R7 recharge restart
    {12'b110001110010, 3'd4, 1'b1},
    {12'b110001111011, 3'd6, 1'b1},  // R6 top-off entry
    {12'b110001111011, 3'd6, 1'b0},
    {12'b110001111011, 3'd6, 1'b0},
    {12'b110001111011, 3'd6, 1'b0},
    {12'b110001111011, 3'd7, 1'b1},  // R6 expiry
    {12'b100001111011, 3'd7, 1'b0},  // R8 bit cleared, hold
    {12'b110001111011, 3'd3, 1'b1},  // R8 bit toggle restart
    {12'b110001111010, 3'd4, 1'b1},
    {12'b110001111010, 3'd7, 1'b1},
    {12'b101001111010, 3'd7, 1'b0},  // R8 pin high, hold
    {12'b110001111010, 3'd3, 1'b1},  // R8 pin toggle restart
    {12'b110101111010, 3'd0, 1'b1},  // R9 thermistor fault
    {12'b110001111010, 3'd3, 1'b1},
    {12'b110011111010, 3'd0, 1'b1},  // R9 timer fault
    {12'b010001111010, 3'd0, 1'b0}   // R2 converter down
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic conv_rdy_i, chg_en_i, ce_ni, ts_fault_i, tmr_fault_i;
  logic vbat_gt_short_i, vbat_gt_lowv_i, vbat_gt_rechg_i;
  logic ibat_lt_term_i, reg_loop_i, vbat_at_reg_i, topoff_en_i;
  logic [2:0] phase_o;
  logic irq_o;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  chg_seq #(.TOPOFF_CYCLES(TOPOFF_N)) u0 (.*);

  task automatic set_in(input logic [11:0] v);
    {conv_rdy_i, chg_en_i, ce_ni, ts_fault_i, tmr_fault_i, vbat_gt_short_i,
     vbat_gt_lowv_i, vbat_gt_rechg_i, ibat_lt_term_i, reg_loop_i,
     vbat_at_reg_i, topoff_en_i} = v;
  endtask

  task automatic check(input string req, input logic [2:0] eph, input logic eirq);
    n_chk++;
    if (phase_o !== eph || irq_o !== eirq) begin
      n_bad++;
      $display("FAIL %s: phase=%0d irq=%0b expected phase=%0d irq=%0b",
               req, phase_o, irq_o, eph, eirq);
    end
  endtask

  task automatic step(input logic [11:0] v, input string req,
                      input logic [2:0] eph, input logic eirq);
    @(negedge clk_i);
    set_in(v);
    @(posedge clk_i);
    #2;
    check(req, eph, eirq);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    set_in(12'b0);
    #2;
    check("R1", 3'd0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    set_in(12'b0);
    #35;
    check("R1", 3'd0, 1'b0);
    rst_ni = 1'b1;
    @(posedge clk_i); #2;
    check("R1", 3'd0, 1'b0);

    for (int i = 0; i < NV; i++)
      step(VEC[i][15:4], "R2-table", VEC[i][3:1], VEC[i][0]);

    // reset mid-charge
    step(12'b110000000000, "R3", 3'd1, 1'b1);
    do_reset();
    @(posedge clk_i); #2;
    check("R1", 3'd0, 1'b0);
    // pre-charge entry
    step(12'b110001000000, "R3", 3'd2, 1'b1);
    // pin high mid-charge
    step(12'b111001000000, "R9", 3'd0, 1'b1);
    // straight to fast, taper, done
    step(12'b110001110000, "R3", 3'd3, 1'b1);
    step(12'b110001110010, "R4", 3'd4, 1'b1);
    step(12'b110001110110, "R5", 3'd4, 1'b0);  // current not low
    step(12'b110001101010, "R5", 3'd4, 1'b0);  // below recharge
    step(12'b110001111010, "R5", 3'd7, 1'b1);
    // disabled and sagging: no restart
    step(12'b100001101010, "R8", 3'd7, 1'b0);
    step(12'b100001101010, "R8", 3'd7, 1'b0);
    // converter lost in done
    step(12'b000001101010, "R9", 3'd0, 1'b1);
    step(12'b000001101010, "R10", 3'd0, 1'b0);
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule